// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level translation table in memory. When a request is accepted, the block captures the virtual address and the current table root. It reads one entry from the outer table, which gives the base of an inner table. It then reads one entry from that inner table, which gives a physical frame. The physical address is the frame followed by the untranslated page offset. The walk ends early with a fault if either entry is marked not present.

Memory is reached through a single read port with a request/response handshake. Only one read is in flight at a time. Every walk reads the outer table first, and only then the inner table. The result comes back as a one-cycle completion pulse. When that pulse carries a fault, it also carries the faulting virtual address. The block takes a new request only while idle. It becomes idle in the same cycle that it signals completion, so a waiting requester can start the next walk at once.

Top module: `pgwalk_core`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, while `mem_req_valid` and `done` are 0.
- R2: The first read of a walk goes to `root_base + vaddr[31:22]*4`, where `root_base` is the value sampled in the accept cycle.
- R3: The second read goes to `{outer_entry[31:12], 12'h000} + vaddr[21:12]*4`. An entry holds the frame number in bits 31:12 and the present flag in bit 0.
- R4: If both entries are present, completion gives `done_fault`=0 and `done_paddr = {inner_entry[31:12], vaddr[11:0]}`. For example, 0x00403004 uses outer index 1, inner index 3 and offset 4.
- R5: If the outer entry has bit 0 clear, completion gives `done_fault`=1 and `done_fault_vaddr`=vaddr, and no inner read is issued.
- R6: If the inner entry has bit 0 clear, completion gives `done_fault`=1 and `done_fault_vaddr`=vaddr.
- R7: Every accepted request produces exactly one `done` pulse, which lasts one cycle.
- R8: `req_ready` is 0 for the whole walk. Values on `req_valid`, `req_vaddr` and `root_base` during that time have no effect on the result.
- R9: Once `mem_req_valid` is raised, it stays high with a stable `mem_req_addr` until the cycle in which `mem_req_ready` is 1.
- R10: A request presented in the cycle that `done` is high is accepted, and that request is walked correctly.
- R11: No new read is issued while a read is waiting for its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| root_base | input | 32 | Byte address of the outer table, sampled when a request is accepted |
| req_valid | input | 1 | A translation request is present |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Block is idle and will take a request |
| mem_req_valid | output | 1 | Table read request |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 32 | Table entry read from memory |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Completion ended in a not-present fault |
| done_paddr | output | 32 | Translated physical address; 0 on a fault |
| done_fault_vaddr | output | 32 | Faulting virtual address; 0 on success |

## Verification
Two things can happen in the same cycle: the completion pulse of one walk and the acceptance of the next request. The bench keeps `req_valid` high for the whole walk, and it changes the address and root every cycle until `req_ready` returns. The request it presents in the completion cycle is therefore the one taken. The reference model checks the finished walk's result in that cycle, and it predicts the next walk's two read addresses from the values presented in that same cycle. The bench counts how often the two events coincide and requires that this happens.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

   typedef enum logic [1:0] {
      WK_IDLE  = 2'd0,
      WK_ISSUE = 2'd1,
      WK_AWAIT = 2'd2
   } wk_state_e;

   function automatic int unsigned pg_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pgwalk_split.sv
module pgwalk_split #(
   parameter int unsigned VA_W    = 32,
   parameter int unsigned OUTER_W = 10,
   parameter int unsigned INNER_W = 10,
   parameter int unsigned OFF_W   = 12
) (
   input  logic [VA_W-1:0]    vaddr,
   output logic [OUTER_W-1:0] outer_idx,
   output logic [INNER_W-1:0] inner_idx,
   output logic [OFF_W-1:0]   page_off
);
   localparam int unsigned INNER_LSB = OFF_W;
   localparam int unsigned OUTER_LSB = OFF_W + INNER_W;

   assign page_off  = vaddr[OFF_W-1:0];
   assign inner_idx = vaddr[INNER_LSB +: INNER_W];
   assign outer_idx = vaddr[OUTER_LSB +: OUTER_W];
endmodule

// File: rtl/pgwalk_pte.sv
module pgwalk_pte #(
   parameter int unsigned PTE_W       = 32,
   parameter int unsigned FRAME_W     = 20,
   parameter int unsigned PRESENT_BIT = 0
) (
   input  logic [PTE_W-1:0]   entry,
   output logic [FRAME_W-1:0] frame,
   output logic               present
);
   localparam int unsigned LOW_W = PTE_W - FRAME_W;

   logic unused_low;

   assign frame      = entry[PTE_W-1 -: FRAME_W];
   assign present    = entry[PRESENT_BIT];
   assign unused_low = ^entry[LOW_W-1:0];
endmodule

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned IDX_W  = 10,
   parameter int unsigned SHIFT  = 2
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] entry_addr
);
   logic [ADDR_W-1:0] idx_ext;
   logic [ADDR_W-1:0] scaled;

   assign idx_ext = ADDR_W'(idx);

   generate
      if (SHIFT == 0) begin : g_byte_entry
         assign scaled = idx_ext;
      end else begin : g_wide_entry
         assign scaled = idx_ext << SHIFT;
      end
   endgenerate

   assign entry_addr = base + scaled;
endmodule

// File: rtl/pgwalk_core.sv
module pgwalk_core
   import pgwalk_pkg::*;
#(
   parameter int unsigned VA_W        = 32,
   parameter int unsigned OUTER_W     = 10,
   parameter int unsigned INNER_W     = 10,
   parameter int unsigned OFF_W       = 12,
   parameter int unsigned PA_W        = 32,
   parameter int unsigned PTE_W       = 32,
   parameter int unsigned ENTRY_BYTES = 4,
   parameter int unsigned PRESENT_BIT = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PA_W-1:0]  root_base,
   input  logic             req_valid,
   input  logic [VA_W-1:0]  req_vaddr,
   output logic             req_ready,
   output logic             mem_req_valid,
   output logic [PA_W-1:0]  mem_req_addr,
   input  logic             mem_req_ready,
   input  logic             mem_rsp_valid,
   input  logic [PTE_W-1:0] mem_rsp_data,
   output logic             done,
   output logic             done_fault,
   output logic [PA_W-1:0]  done_paddr,
   output logic [VA_W-1:0]  done_fault_vaddr
);
   localparam int unsigned FRAME_W = PA_W - OFF_W;
   localparam int unsigned IDX_W   = pg_max(OUTER_W, INNER_W);
   localparam int unsigned SHIFT   = $clog2(ENTRY_BYTES);

   generate
      if (OUTER_W + INNER_W + OFF_W != VA_W) begin : g_bad_split
         $error("index and offset widths must fill the virtual address");
      end
      if (FRAME_W >= PTE_W) begin : g_bad_frame
         $error("entry must hold the frame plus a flag field");
      end
      if (PRESENT_BIT >= PTE_W - FRAME_W) begin : g_bad_flag
         $error("present flag must sit below the frame field");
      end
      if ((1 << SHIFT) != ENTRY_BYTES) begin : g_bad_entry
         $error("entry size must be a power of two");
      end
      if (IDX_W + SHIFT >= PA_W) begin : g_bad_idx
         $error("scaled index must fit the address");
      end
   endgenerate

   wk_state_e         state_q;
   logic              lvl_q;
   logic [VA_W-1:0]   va_q;
   logic [PA_W-1:0]   base_q;

   logic [OUTER_W-1:0] outer_idx;
   logic [INNER_W-1:0] inner_idx;
   logic [OFF_W-1:0]   page_off;
   logic [IDX_W-1:0]   idx_sel;
   logic [FRAME_W-1:0] rsp_frame;
   logic               rsp_present;

   logic               done_q;
   logic               fault_q;
   logic [PA_W-1:0]    paddr_q;
   logic [VA_W-1:0]    fva_q;

   pgwalk_split #(
      .VA_W(VA_W), .OUTER_W(OUTER_W), .INNER_W(INNER_W), .OFF_W(OFF_W)
   ) u_split (
      .vaddr(va_q), .outer_idx(outer_idx), .inner_idx(inner_idx), .page_off(page_off)
   );

   pgwalk_pte #(
      .PTE_W(PTE_W), .FRAME_W(FRAME_W), .PRESENT_BIT(PRESENT_BIT)
   ) u_pte (
      .entry(mem_rsp_data), .frame(rsp_frame), .present(rsp_present)
   );

   assign idx_sel = lvl_q ? IDX_W'(inner_idx) : IDX_W'(outer_idx);

   pgwalk_addr #(
      .ADDR_W(PA_W), .IDX_W(IDX_W), .SHIFT(SHIFT)
   ) u_addr (
      .base(base_q), .idx(idx_sel), .entry_addr(mem_req_addr)
   );

   assign req_ready     = (state_q == WK_IDLE);
   assign mem_req_valid = (state_q == WK_ISSUE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WK_IDLE;
         lvl_q   <= 1'b0;
         va_q    <= '0;
         base_q  <= '0;
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         paddr_q <= '0;
         fva_q   <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            WK_IDLE: begin
               if (req_valid) begin
                  va_q    <= req_vaddr;
                  base_q  <= root_base;
                  lvl_q   <= 1'b0;
                  state_q <= WK_ISSUE;
               end
            end
            WK_ISSUE: begin
               if (mem_req_ready) begin
                  state_q <= WK_AWAIT;
               end
            end
            WK_AWAIT: begin
               if (mem_rsp_valid) begin
                  if (!rsp_present) begin
                     done_q  <= 1'b1;
                     fault_q <= 1'b1;
                     paddr_q <= '0;
                     fva_q   <= va_q;
                     state_q <= WK_IDLE;
                  end else if (!lvl_q) begin
                     base_q  <= {rsp_frame, {OFF_W{1'b0}}};
                     lvl_q   <= 1'b1;
                     state_q <= WK_ISSUE;
                  end else begin
                     done_q  <= 1'b1;
                     fault_q <= 1'b0;
                     paddr_q <= {rsp_frame, page_off};
                     fva_q   <= '0;
                     state_q <= WK_IDLE;
                  end
               end
            end
            default: state_q <= WK_IDLE;
         endcase
      end
   end

   assign done             = done_q;
   assign done_fault       = fault_q;
   assign done_paddr       = paddr_q;
   assign done_fault_vaddr = fva_q;
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
   parameter int unsigned VA_W        = 32,
   parameter int unsigned OUTER_W     = 10,
   parameter int unsigned OFF_W       = 12,
   parameter int unsigned PA_W        = 32,
   parameter int unsigned ENTRY_BYTES = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic [PA_W-1:0] root_base,
   input logic            req_valid,
   input logic [VA_W-1:0] req_vaddr,
   input logic            req_ready,
   input logic            mem_req_valid,
   input logic [PA_W-1:0] mem_req_addr,
   input logic            mem_req_ready,
   input logic            mem_rsp_valid,
   input logic            done,
   input logic            done_fault,
   input logic [PA_W-1:0] done_paddr,
   input logic [VA_W-1:0] done_fault_vaddr
);
   logic [VA_W-1:0] cap_va;
   logic [PA_W-1:0] cap_root;
   logic            first_pending;
   logic            in_flight;
   logic [PA_W-1:0] first_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_va        <= '0;
         cap_root      <= '0;
         first_pending <= 1'b0;
         in_flight     <= 1'b0;
      end else begin
         if (req_valid && req_ready) begin
            cap_va        <= req_vaddr;
            cap_root      <= root_base;
            first_pending <= 1'b1;
         end else if (mem_req_valid && mem_req_ready) begin
            first_pending <= 1'b0;
         end
         if (mem_req_valid && mem_req_ready) begin
            in_flight <= 1'b1;
         end else if (mem_rsp_valid) begin
            in_flight <= 1'b0;
         end
      end
   end

   assign first_addr = cap_root
                     + PA_W'(cap_va[VA_W-1 -: OUTER_W]) * PA_W'(ENTRY_BYTES);

   p_outer_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && first_pending) |-> (mem_req_addr == first_addr));

   p_offset_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !done_fault) |-> (done_paddr[OFF_W-1:0] == cap_va[OFF_W-1:0]));

   p_fault_va_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_fault) |-> (done_fault_vaddr == cap_va));

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_idle_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);

   p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready);

   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   p_one_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
      in_flight |-> !mem_req_valid);
endmodule

bind pgwalk_core pgwalk_chk #(
   .VA_W(VA_W), .OUTER_W(OUTER_W), .OFF_W(OFF_W), .PA_W(PA_W), .ENTRY_BYTES(ENTRY_BYTES)
) u_pgwalk_chk (
   .clk(clk), .rst_n(rst_n), .root_base(root_base), .req_valid(req_valid),
   .req_vaddr(req_vaddr), .req_ready(req_ready), .mem_req_valid(mem_req_valid),
   .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
   .mem_rsp_valid(mem_rsp_valid), .done(done), .done_fault(done_fault),
   .done_paddr(done_paddr), .done_fault_vaddr(done_fault_vaddr)
);

// File: tb/pgwalk_core_bench.sv
`timescale 1ns/1ps
module pgwalk_core_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] root_base = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        req_ready;
   logic        mem_req_valid;
   logic [31:0] mem_req_addr;
   logic        mem_req_ready = 1'b0;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        done;
   logic        done_fault;
   logic [31:0] done_paddr;
   logic [31:0] done_fault_vaddr;

   always #2 clk = ~clk;

   pgwalk_core u_pgwalk_core (
      .clk(clk), .rst_n(rst_n), .root_base(root_base), .req_valid(req_valid),
      .req_vaddr(req_vaddr), .req_ready(req_ready), .mem_req_valid(mem_req_valid),
      .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .done(done),
      .done_fault(done_fault), .done_paddr(done_paddr), .done_fault_vaddr(done_fault_vaddr)
   );

   int checks = 0;
   int fails = 0;
   int coincide = 0;
   bit finished = 1'b0;

   logic [31:0] table_ov [logic [31:0]];

   typedef struct packed {
      logic        flt;
      logic [31:0] pa;
      logic [31:0] fva;
   } exp_t;

   typedef struct packed {
      logic [31:0] addr;
      logic        inner;
   } rd_t;

   exp_t exp_q[$];
   rd_t  rd_q[$];

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      if (table_ov.exists(a)) return table_ov[a];
      return {a[21:2] ^ 20'hA5C3E, 11'h000, 1'b1};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic model_accept(input logic [31:0] va, input logic [31:0] root);
      logic [31:0] oa, ia, oe, ie;
      exp_t e;
      oa = root + {20'h0, va[31:22], 2'b00};
      rd_q.push_back('{addr: oa, inner: 1'b0});
      oe = mem_word(oa);
      if (!oe[0]) begin
         e = '{flt: 1'b1, pa: 32'h0, fva: va};
      end else begin
         ia = {oe[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
         rd_q.push_back('{addr: ia, inner: 1'b1});
         ie = mem_word(ia);
         if (!ie[0]) e = '{flt: 1'b1, pa: 32'h0, fva: va};
         else        e = '{flt: 1'b0, pa: {ie[31:12], va[11:0]}, fva: 32'h0};
      end
      exp_q.push_back(e);
   endtask

   logic done_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (mem_req_valid && mem_req_ready) begin
            if (rd_q.size() == 0) begin
               chk(1'b0, "R5 unexpected read", mem_req_addr, 32'h0);
            end else begin
               rd_t r;
               r = rd_q.pop_front();
               chk(mem_req_addr == r.addr, r.inner ? "R3 inner addr" : "R2 outer addr",
                   mem_req_addr, r.addr);
            end
         end
         if (mem_req_valid && mem_rsp_valid)
            chk(1'b0, "R11 read during response", 32'h1, 32'h0);
         if (done && done_prev)
            chk(1'b0, "R7 pulse width", 32'h1, 32'h0);
         if (done) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R7 extra done", 32'h1, 32'h0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(done_fault == e.flt, e.flt ? "R5/R6 fault flag" : "R4 fault flag",
                   {31'h0, done_fault}, {31'h0, e.flt});
               chk(done_paddr == e.pa, "R4 paddr", done_paddr, e.pa);
               chk(done_fault_vaddr == e.fva, "R5/R6 fault vaddr", done_fault_vaddr, e.fva);
               if (!e.flt && rd_q.size() != 0)
                  chk(1'b0, "R5 leftover read", 32'h1, 32'h0);
            end
            if (req_valid && req_ready) coincide++;
         end
         if (req_valid && req_ready) model_accept(req_vaddr, root_base);
         done_prev = done;
      end
   end

   // memory responder, acts just after each rising edge
   initial begin
      bit          pending = 1'b0;
      int          cnt = 0;
      int          cyc = 0;
      logic [31:0] pend_a = '0;
      bit          prev_hs = 1'b0;
      logic [31:0] prev_a = '0;
      forever begin
         @(posedge clk); #1;
         cyc++;
         mem_rsp_valid = 1'b0;
         if (rst_n) begin
            if (prev_hs) begin
               pending = 1'b1;
               pend_a  = prev_a;
               cnt     = cyc % 3;
            end
            if (pending) begin
               if (cnt == 0) begin
                  mem_rsp_valid = 1'b1;
                  mem_rsp_data  = mem_word(pend_a);
                  pending       = 1'b0;
               end else begin
                  cnt--;
               end
            end
            mem_req_ready = (cyc % 4) != 2;
            prev_hs = mem_req_valid && mem_req_ready;
            prev_a  = mem_req_addr;
         end
      end
   end

   task automatic issue(input logic [31:0] va, input logic [31:0] root);
      int n = 0;
      while (!req_ready) begin
         req_valid = 1'b1;
         req_vaddr = ~va ^ n;
         root_base = 32'hDEAD_0000 + n;
         n++;
         @(posedge clk); #1;
      end
      req_valid = 1'b1;
      req_vaddr = va;
      root_base = root;
      @(posedge clk); #1;
   endtask

   task automatic idle(input int n);
      req_valid = 1'b0;
      req_vaddr = 32'hFFFF_FFFF;
      repeat (n) begin
         @(posedge clk); #1;
      end
   endtask

   task automatic drain();
      int guard = 0;
      while ((!req_ready || exp_q.size() != 0) && guard < 200) begin
         req_valid = 1'b0;
         @(posedge clk); #1;
         guard++;
      end
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] lf;
      table_ov[32'h0001_0004] = 32'h0002_0001;
      table_ov[32'h0002_000C] = 32'h1234_5001;
      table_ov[32'h0001_0014] = 32'h0003_0000;
      table_ov[32'h0002_0014] = 32'h7777_7000;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, "R1 req_ready", {31'h0, req_ready}, 32'h1);
      chk(mem_req_valid == 1'b0, "R1 mem_req_valid", {31'h0, mem_req_valid}, 32'h0);
      chk(done == 1'b0, "R1 done", {31'h0, done}, 32'h0);
      @(posedge clk); #1;

      issue(32'h0040_3004, 32'h0001_0000);   // R4 worked example
      idle(12);
      issue(32'h0140_0ABC, 32'h0001_0000);   // R5 outer not present
      idle(8);
      issue(32'h0040_5123, 32'h0001_0000);   // R6 inner not present
      drain();
      // R8 R10 back-to-back with decoys while busy
      issue(32'h0040_3FFF, 32'h0001_0000);
      issue(32'h0140_0001, 32'h0001_0000);
      issue(32'h0040_5000, 32'h0001_0000);
      issue(32'hFFFF_F7A1, 32'h0008_0000);
      lf = 32'hACE1_1234;
      for (int i = 0; i < 40; i++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         issue(lf, (i % 3 == 0) ? 32'h0001_0000 : {lf[15:4], 20'h0});
         if (i % 7 == 6) idle(i % 4);
      end
      drain();

      chk(exp_q.size() == 0, "R7 all walks completed", exp_q.size(), 32'h0);
      chk(rd_q.size() == 0, "R2/R3 all reads seen", rd_q.size(), 32'h0);
      chk(coincide > 0, "R10 done with accept", coincide, 32'h1);
      chk(req_ready == 1'b1, "R8 idle after drain", {31'h0, req_ready}, 32'h1);
      finish_run();
   end
endmodule